// File: doc/BRIEF.md
# Stack-Based Four-Bit Calculator

This block is a small calculator whose only storage for operands is a four-entry, four-bit hardware stack. An 8-bit switch bus carries an opcode in its upper nibble and an operand in its lower nibble. A strobe on the execute input starts one instruction. The three supported instructions are push, pop and add. The top of stack always drives the 4-bit data output. A separate flag output holds the carry from the most recent add.

Every instruction takes the same fixed walk through four controller states: idle, first operand, second operand, write-back. Each state issues its own stack, temporary-register and ALU actions for the latched opcode. The stack has no address. A push shifts every entry down and drops the bottom entry. A pop shifts every entry up and brings zero into the bottom. A simple host drives the bus, raises execute, and reads the result once the instruction has finished.

Top module: `stack_calc`

## Requirements
- R1: While rst_n is low at a rising clock edge, all four stack entries, the flag and the temporary register are cleared to zero, so that tos_out and flag_out read 0 afterwards.
- R2: Opcode 4'b0000 (push) places sw_bus[3:0] on top of the stack. The entries below it keep their earlier order, each moved down one place.
- R3: Opcode 4'b0001 (pop) removes the top entry, and every remaining entry moves up one place. A zero enters the bottom place, so popping an empty stack reads 0.
- R4: Opcode 4'b0010 (add) removes the top two entries a and b and pushes (a+b) mod 16. flag_out becomes bit 4 of a+b.
- R5: A push onto a stack that already holds four values discards the bottom value. The remaining three values stay in order below the new top.
- R6: Execute is sampled only in the idle state, and only after execute has been seen low. An execute held high for any number of cycles therefore runs exactly one instruction. An instruction reaches idle again four clock edges after it starts.
- R7: Any opcode from 4'b0011 to 4'b1111 leaves all stack entries and the flag unchanged.
- R8: flag_out keeps its value through push, pop and undefined instructions, and changes only when an add completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_bus | input | 8 | [7:4] opcode, [3:0] operand; must be held steady while an instruction runs |
| exec_req | input | 1 | Active-high execute strobe |
| tos_out | output | 4 | Current top-of-stack entry |
| flag_out | output | 1 | Carry from the most recent add |

## Verification
On every cycle the assertions check four things. The first is the fixed controller walk and the rule that no new instruction starts before execute is released. The second is the local stack rules: a push writes the operand on top, a pop brings zero into the bottom, and a hold leaves the entries unchanged. The third is that the add stores its sum and carry. The fourth is that the flag holds between adds.

Some behaviour needs whole sequences of instructions, and only the bench scenarios can show it. This covers the order of the stack contents after overflow and underflow, and the results of all 256 operand pairs of the add. It also covers the absence of any effect from the thirteen undefined opcodes, and the single run produced by a long execute pulse. The bench shows all of these by draining the stack through pops.

// File: rtl/calc_pkg.sv
// Package: shared encodings for the stack calculator.
// Assumes the opcode field is four bits wide; values outside the three listed are no-ops.
package calc_pkg;

    // Controller states, walked in this order for every instruction.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPA  = 2'd1,
        ST_OPB  = 2'd2,
        ST_WBK  = 2'd3
    } ctrl_state_t;

    // Stack operation select.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_t;

    // ALU function select.
    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADD  = 3'd1
    } alu_op_t;

    // Source of the temporary register load.
    typedef enum logic {
        SRC_INPUT = 1'b0,
        SRC_ALU   = 1'b1
    } tmp_src_t;

    // Opcode values carried in the upper nibble of the switch bus.
    localparam logic [3:0] OPC_PUSH = 4'b0000;
    localparam logic [3:0] OPC_POP  = 4'b0001;
    localparam logic [3:0] OPC_ADD  = 4'b0010;

endpackage

// File: rtl/calc_ctrl.sv
// Module: calc_ctrl
// Four-state Moore controller. It latches the opcode when an instruction starts,
// walks idle -> first operand -> second operand -> write-back -> idle, and decodes
// stack, ALU and temporary-register controls from the state and the latched opcode.
// Assumes exec_req is synchronous to clk.
module calc_ctrl
    import calc_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_req,
    input  logic [OP_W-1:0] opcode,
    output stk_op_t         stk_op,
    output alu_op_t         alu_sel,
    output tmp_src_t        tmp_src,
    output logic            tmp_we,
    output logic            carry_we
);

    ctrl_state_t     state_q, state_d;
    logic [OP_W-1:0] op_q;
    logic            armed_q;
    logic            start;

    assign start = (state_q == ST_IDLE) && exec_req && armed_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state function: fixed walk once started.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_OPA;
            ST_OPA:  state_d = ST_OPB;
            ST_OPB:  state_d = ST_WBK;
            ST_WBK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Opcode latch and re-arm tracking: execute must drop before the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            armed_q <= 1'b1;
        end else begin
            if (start) begin
                op_q    <= opcode;
                armed_q <= 1'b0;
            end else if (!exec_req) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Moore output decode from current state and latched opcode.
    always_comb begin
        stk_op   = STK_HOLD;
        alu_sel  = ALU_PASS;
        tmp_src  = SRC_INPUT;
        tmp_we   = 1'b0;
        carry_we = 1'b0;
        if (op_q == OP_W'(OPC_PUSH)) begin
            case (state_q)
                ST_OPB: begin
                    tmp_src = SRC_INPUT;
                    tmp_we  = 1'b1;
                end
                ST_WBK:  stk_op = STK_PUSH;
                default: ;
            endcase
        end else if (op_q == OP_W'(OPC_POP)) begin
            if (state_q == ST_OPA) stk_op = STK_POP;
        end else if (op_q == OP_W'(OPC_ADD)) begin
            case (state_q)
                ST_OPA: begin
                    tmp_src = SRC_ALU;
                    alu_sel = ALU_PASS;
                    tmp_we  = 1'b1;
                    stk_op  = STK_POP;
                end
                ST_OPB: begin
                    tmp_src  = SRC_ALU;
                    alu_sel  = ALU_ADD;
                    tmp_we   = 1'b1;
                    carry_we = 1'b1;
                    stk_op   = STK_POP;
                end
                ST_WBK:  stk_op = STK_PUSH;
                default: ;
            endcase
        end
    end

    // R6: the walk is fixed once an instruction starts.
    p_walk_opa_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPA) |=> (state_q == ST_OPB));
    p_walk_opb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPB) |=> (state_q == ST_WBK));
    p_walk_wbk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBK) |=> (state_q == ST_IDLE));
    // R6: no restart while execute has not been released.
    p_no_rerun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !armed_q) |=> (state_q == ST_IDLE));
    // R7: undefined opcodes never touch the stack.
    p_undef_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q > OP_W'(OPC_ADD)) |-> (stk_op == STK_HOLD && !carry_we));

endmodule

// File: rtl/calc_alu.sv
// Module: calc_alu
// Combinational ALU. It either passes the top of stack through or adds it to the
// temporary register. The result is one bit wider so that the carry is kept.
module calc_alu
    import calc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  alu_op_t           alu_sel,
    input  logic [DATA_W-1:0] tos,
    input  logic [DATA_W-1:0] tmp,
    output logic [DATA_W:0]   result
);

    // Function select.
    always_comb begin
        case (alu_sel)
            ALU_ADD: result = {1'b0, tos} + {1'b0, tmp};
            default: result = {1'b0, tos};
        endcase
    end

endmodule

// File: rtl/calc_datapath.sv
// Module: calc_datapath
// Temporary register, input/ALU source mux and carry flag register. The temporary
// register feeds the stack's push data. Assumes the controls come from calc_ctrl.
module calc_datapath
    import calc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] tos,
    input  alu_op_t           alu_sel,
    input  tmp_src_t          tmp_src,
    input  logic              tmp_we,
    input  logic              carry_we,
    output logic [DATA_W-1:0] tmp_out,
    output logic              flag
);

    logic [DATA_W:0]   alu_res;
    logic [DATA_W-1:0] tmp_q;
    logic [DATA_W-1:0] tmp_next;
    logic              flag_q;

    calc_alu #(.DATA_W(DATA_W)) alu_i (
        .alu_sel (alu_sel),
        .tos     (tos),
        .tmp     (tmp_q),
        .result  (alu_res)
    );

    // Source mux for the temporary register.
    always_comb begin
        tmp_next = (tmp_src == SRC_ALU) ? alu_res[DATA_W-1:0] : din;
    end

    // Temporary register and carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (tmp_we)   tmp_q  <= tmp_next;
            if (carry_we) flag_q <= alu_res[DATA_W];
        end
    end

    assign tmp_out = tmp_q;
    assign flag    = flag_q;

    // R8: the flag only moves on the add step.
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_we |=> $stable(flag_q));
    // R4: the add step stores sum and carry together.
    p_add_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |=> ({flag_q, tmp_q} == ($past({1'b0, tos}) + $past({1'b0, tmp_q}))));

endmodule

// File: rtl/calc_stack.sv
// Module: calc_stack
// Address-free stack built from flip-flops. A push shifts down and loses the bottom
// entry. A pop shifts up and fills the bottom with zero. Only the top is an output.
module calc_stack
    import calc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_t           op,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top
);

    logic [DATA_W-1:0] ent_q [DEPTH];

    // Entry shift register for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            case (op)
                STK_PUSH: begin
                    ent_q[0] <= push_data;
                    for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
                end
                STK_POP: begin
                    for (int i = 0; i < DEPTH-1; i++) ent_q[i] <= ent_q[i+1];
                    ent_q[DEPTH-1] <= '0;
                end
                default: ;
            endcase
        end
    end

    assign top = ent_q[0];

    // R2: a push puts the push data on top.
    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH) |=> (ent_q[0] == $past(push_data)));
    // R3: a pop fills the bottom entry with zero.
    p_pop_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP) |=> (ent_q[DEPTH-1] == '0));
    // R7: a hold leaves the top and bottom entries unchanged.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_HOLD) |=> ($stable(ent_q[0]) && $stable(ent_q[DEPTH-1])));

endmodule

// File: rtl/stack_calc.sv
// Module: stack_calc (top)
// Stack calculator: the controller sequences the stack, the temporary register and
// the ALU. The switch bus carries the opcode in the upper field and the operand in
// the lower field. Assumes sw_bus stays steady while an instruction runs.
module stack_calc
    import calc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int OP_W   = 4,
    parameter int DEPTH  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OP_W+DATA_W-1:0] sw_bus,
    input  logic                   exec_req,
    output logic [DATA_W-1:0]      tos_out,
    output logic                   flag_out
);

    localparam int BUS_W = OP_W + DATA_W;

    stk_op_t           stk_op;
    alu_op_t           alu_sel;
    tmp_src_t          tmp_src;
    logic              tmp_we;
    logic              carry_we;
    logic [DATA_W-1:0] tos;
    logic [DATA_W-1:0] tmp;

    calc_ctrl #(.OP_W(OP_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_req (exec_req),
        .opcode   (sw_bus[BUS_W-1:DATA_W]),
        .stk_op   (stk_op),
        .alu_sel  (alu_sel),
        .tmp_src  (tmp_src),
        .tmp_we   (tmp_we),
        .carry_we (carry_we)
    );

    calc_datapath #(.DATA_W(DATA_W)) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (sw_bus[DATA_W-1:0]),
        .tos      (tos),
        .alu_sel  (alu_sel),
        .tmp_src  (tmp_src),
        .tmp_we   (tmp_we),
        .carry_we (carry_we),
        .tmp_out  (tmp),
        .flag     (flag_out)
    );

    calc_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) stk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_data (tmp),
        .top       (tos)
    );

    assign tos_out = tos;

endmodule

// File: tb/stack_calc_tb_top.sv
`timescale 1ns/1ps
module stack_calc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw_bus = '0;
    logic       exec_req = 1'b0;
    logic [3:0] tos_out;
    logic       flag_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mdl [4];
    int mflag = 0;

    always #2 clk = ~clk;

    stack_calc dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_bus   (sw_bus),
        .exec_req (exec_req),
        .tos_out  (tos_out),
        .flag_out (flag_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_push(input int v);
        for (int i = 3; i > 0; i--) mdl[i] = mdl[i-1];
        mdl[0] = v & 15;
    endtask

    task automatic m_pop();
        for (int i = 0; i < 3; i++) mdl[i] = mdl[i+1];
        mdl[3] = 0;
    endtask

    // Run one instruction with execute held for hold_cyc cycles, and update the model.
    task automatic run(input int op, input int data, input int hold_cyc);
        int a, b;
        sw_bus = {op[3:0], data[3:0]};
        @(negedge clk);
        exec_req = 1'b1;
        repeat (hold_cyc) @(negedge clk);
        exec_req = 1'b0;
        repeat (2) @(negedge clk);
        case (op)
            0: m_push(data);
            1: m_pop();
            2: begin
                a = mdl[0]; m_pop();
                b = mdl[0]; m_pop();
                m_push(a + b);
                mflag = ((a + b) >> 4) & 1;
            end
            default: ;
        endcase
    endtask

    // Pop all entries and compare each one with the model.
    task automatic drain(input string req);
        for (int i = 0; i < 4; i++) begin
            check(req, tos_out, mdl[0]);
            run(1, 0, 6);
        end
        check(req, tos_out, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", tos_out, 0);
        check("R1", flag_out, 0);
        drain("R1");

        // R2: push every value; the stack overflows along the way (R5)
        for (int v = 0; v < 16; v++) begin
            run(0, v, 6);
            check("R2", tos_out, v);
        end
        // R5: contents after overflow are 15,14,13,12; R3: then a zero fill
        drain("R5");
        run(1, 0, 6);
        check("R3", tos_out, 0);

        // R4: all operand pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run(0, a, 6);
                run(0, b, 6);
                run(2, 0, 6);
                check("R4", tos_out, (a + b) & 15);
                check("R4", flag_out, ((a + b) >> 4) & 1);
            end
        end

        // R8: the flag persists through push and pop until the next add
        run(0, 15, 6); run(0, 1, 6); run(2, 0, 6);
        check("R8", flag_out, 1);
        run(0, 3, 6); run(1, 0, 6); run(0, 7, 6);
        check("R8", flag_out, 1);
        run(0, 1, 6); run(0, 1, 6); run(2, 0, 6);
        check("R8", flag_out, 0);
        check("R8", tos_out, 2);

        // R7: undefined opcodes change nothing
        run(0, 5, 6); run(0, 9, 6); run(0, 15, 6); run(2, 0, 6);
        for (int op = 3; op < 16; op++) begin
            run(op, 6, 6);
            check("R7", tos_out, mdl[0]);
            check("R7", flag_out, mflag);
        end
        drain("R7");

        // R6: a long execute pulse runs one push only
        run(0, 4, 6);
        run(0, 9, 40);
        check("R6", tos_out, 9);
        drain("R6");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule